// File: doc/BRIEF.md
# Multi-Ratio Clock Pulse Divider

This block takes a single incoming pulse stream (for example a tempo clock or an audio-rate square wave) and derives seven slower pulse streams from it, dividing by 2, 3, 4, 5, 6, 7 and 8. The slower streams can drive polyrhythms or serve as sub-harmonics. The input is treated as asynchronous. It is brought into the system clock domain, and each of its rising edges advances every divider by one count.

The outputs are grouped into families with locked phase. Divide-by-4 fires only on a pulse where divide-by-2 also fires, and divide-by-8 fires only on a pulse where divide-by-4 fires. Divide-by-6 fires only on a pulse where divide-by-3 fires. The divide-by-5 and divide-by-7 outputs stand alone. A single synchronous reset clears every counter so that all families restart together, and it holds all seven outputs high while it is asserted. An output that fires copies the input's high phase: it rises with the input pulse on which its count wraps and falls when that pulse ends.

Top module: `pulse_divider_top`

## Requirements
- R1: After reset is released, input pulses are numbered 1, 2, 3 and so on. The output for ratio N is high during pulse k exactly when k is a multiple of N, for N in {2,3,4,5,6,7,8}.
- R2: An output that fires rises on the third rising edge of `clk` after `pulse_in` rises. This latency comes from two synchronizer flops and one output register.
- R3: A firing output stays high for the whole high phase of that input pulse. It goes low on the third `clk` edge after `pulse_in` falls, and it is low during every pulse on which its count does not wrap.
- R4: `div4_o` is never high unless `div2_o` is high.
- R5: `div8_o` is never high unless `div4_o` is high.
- R6: `div6_o` is never high unless `div3_o` is high.
- R7: While `rst` is sampled high, every counter is cleared and all seven outputs are high from the following edge on. Once reset is released with the input low, the outputs drop, and the next input pulse counts as pulse 1.
- R8: An input held high for many `clk` cycles counts as one pulse only. Only its rising edge advances the dividers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset shared by all dividers |
| pulse_in | input | 1 | Asynchronous input pulse stream |
| div2_o | output | 1 | Pulse every 2nd input pulse |
| div3_o | output | 1 | Pulse every 3rd input pulse |
| div4_o | output | 1 | Pulse every 4th input pulse |
| div5_o | output | 1 | Pulse every 5th input pulse |
| div6_o | output | 1 | Pulse every 6th input pulse |
| div7_o | output | 1 | Pulse every 7th input pulse |
| div8_o | output | 1 | Pulse every 8th input pulse |

## Verification
Assertions check on every cycle that the families stay nested (R4 to R6) and that reset forces all outputs high. They also check that the edge strobe never lasts two cycles, that an output rises only on a wrapping strobe and falls only once the synchronized input is low, and that each counter returns to zero when it wraps. Some behaviour can be shown only by the bench's pulse scenarios: the actual period of each ratio counted from reset, the three-edge latency on both edges of the input, that a long-held input counts once, and that a mid-stream reset makes the next pulse count 1.

// File: rtl/pulse_divider_pkg.sv
package pulse_divider_pkg;

  localparam int NUM_OUTS = 7;

  // Output slot order used internally: ratio = slot + 2
  localparam int SLOT_D2 = 0;
  localparam int SLOT_D3 = 1;
  localparam int SLOT_D4 = 2;
  localparam int SLOT_D5 = 3;
  localparam int SLOT_D6 = 4;
  localparam int SLOT_D7 = 5;
  localparam int SLOT_D8 = 6;

  typedef logic [NUM_OUTS-1:0] out_vec_t;

  function automatic int cnt_width(input int ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction

endpackage

// File: rtl/pd_input_sync.sv
module pd_input_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level_o,
  output logic advance_o
);

  logic [SYNC_STAGES-1:0] sync_sr;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_sr <= '0;
      prev_q  <= 1'b0;
    end else begin
      sync_sr <= {sync_sr[SYNC_STAGES-2:0], async_in};
      prev_q  <= sync_sr[SYNC_STAGES-1];
    end
  end

  assign level_o   = sync_sr[SYNC_STAGES-1];
  assign advance_o = level_o & ~prev_q;

  // R8: a held-high input produces a single one-cycle advance strobe
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
    advance_o |=> !advance_o)
    else $error("advance strobe lasted more than one cycle");

endmodule

// File: rtl/pd_count_stage.sv
module pd_count_stage #(
  parameter int RATIO = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic wrap_o
);

  localparam int CW = pulse_divider_pkg::cnt_width(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt;

  assign wrap_o = tick_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick_i) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + CW'(1);
    end
  end

  // R1: a counted tick at the last count returns the counter to zero
  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt == '0))
    else $error("counter did not return to zero after wrap");

endmodule

// File: rtl/pd_out_stage.sv
module pd_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic advance_i,
  input  logic level_i,
  input  logic wrap_i,
  output logic q_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= 1'b1;
    end else if (advance_i) begin
      q_o <= wrap_i;
    end else if (!level_i) begin
      q_o <= 1'b0;
    end
  end

  // R2: an output only rises on an advance strobe whose count wraps
  a_r2_rise_on_wrap: assert property (@(posedge clk) disable iff (rst)
    $rose(q_o) |-> $past(advance_i && wrap_i))
    else $error("output rose without a wrapping advance");

  // R3: an output only falls once the input is low or a non-wrapping pulse starts
  a_r3_fall_on_low: assert property (@(posedge clk) disable iff (rst)
    $fell(q_o) |-> $past(!level_i || advance_i))
    else $error("output fell while input still high");

endmodule

// File: rtl/pulse_divider_top.sv
module pulse_divider_top #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic div2_o,
  output logic div3_o,
  output logic div4_o,
  output logic div5_o,
  output logic div6_o,
  output logic div7_o,
  output logic div8_o
);

  import pulse_divider_pkg::*;

  logic     level;
  logic     advance;
  out_vec_t wraps;
  out_vec_t outs;

  pd_input_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .async_in  (pulse_in),
    .level_o   (level),
    .advance_o (advance)
  );

  // Binary family: each stage halves the wraps of the one before
  pd_count_stage #(.RATIO(2)) u_cnt2 (
    .clk(clk), .rst(rst), .tick_i(advance),        .wrap_o(wraps[SLOT_D2]));
  pd_count_stage #(.RATIO(2)) u_cnt4 (
    .clk(clk), .rst(rst), .tick_i(wraps[SLOT_D2]), .wrap_o(wraps[SLOT_D4]));
  pd_count_stage #(.RATIO(2)) u_cnt8 (
    .clk(clk), .rst(rst), .tick_i(wraps[SLOT_D4]), .wrap_o(wraps[SLOT_D8]));

  // Ternary family: divide-by-6 halves the divide-by-3 wraps
  pd_count_stage #(.RATIO(3)) u_cnt3 (
    .clk(clk), .rst(rst), .tick_i(advance),        .wrap_o(wraps[SLOT_D3]));
  pd_count_stage #(.RATIO(2)) u_cnt6 (
    .clk(clk), .rst(rst), .tick_i(wraps[SLOT_D3]), .wrap_o(wraps[SLOT_D6]));

  // Standalone ratios
  pd_count_stage #(.RATIO(5)) u_cnt5 (
    .clk(clk), .rst(rst), .tick_i(advance),        .wrap_o(wraps[SLOT_D5]));
  pd_count_stage #(.RATIO(7)) u_cnt7 (
    .clk(clk), .rst(rst), .tick_i(advance),        .wrap_o(wraps[SLOT_D7]));

  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_out
    pd_out_stage u_out (
      .clk       (clk),
      .rst       (rst),
      .advance_i (advance),
      .level_i   (level),
      .wrap_i    (wraps[g]),
      .q_o       (outs[g])
    );
  end

  assign div2_o = outs[SLOT_D2];
  assign div3_o = outs[SLOT_D3];
  assign div4_o = outs[SLOT_D4];
  assign div5_o = outs[SLOT_D5];
  assign div6_o = outs[SLOT_D6];
  assign div7_o = outs[SLOT_D7];
  assign div8_o = outs[SLOT_D8];

  // R4
  a_r4_div4_nested: assert property (@(posedge clk) disable iff (rst)
    div4_o |-> div2_o)
    else $error("div4 fired without div2");

  // R5
  a_r5_div8_nested: assert property (@(posedge clk) disable iff (rst)
    div8_o |-> div4_o)
    else $error("div8 fired without div4");

  // R6
  a_r6_div6_nested: assert property (@(posedge clk) disable iff (rst)
    div6_o |-> div3_o)
    else $error("div6 fired without div3");

  // R7
  a_r7_reset_all_high: assert property (@(posedge clk)
    rst |=> (&outs))
    else $error("outputs not all high during reset");

endmodule

// File: tb/pulse_divider_top_tb.sv
module pulse_divider_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  typedef struct {
    logic [6:0] vec;
    int         hi;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst;
  logic pulse_in;
  logic div2_o, div3_o, div4_o, div5_o, div6_o, div7_o, div8_o;

  int checks = 0;
  int errors = 0;
  int pulse_no = 0;
  bit done = 1'b0;
  exp_item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_divider_top u_dut (
    .clk(clk), .rst(rst), .pulse_in(pulse_in),
    .div2_o(div2_o), .div3_o(div3_o), .div4_o(div4_o), .div5_o(div5_o),
    .div6_o(div6_o), .div7_o(div7_o), .div8_o(div8_o)
  );

  function automatic logic [6:0] outs_now();
    return {div8_o, div7_o, div6_o, div5_o, div4_o, div3_o, div2_o};
  endfunction

  // bit i corresponds to ratio i+2
  function automatic logic [6:0] expect_for(input int k);
    logic [6:0] v;
    for (int i = 0; i < 7; i++) v[i] = ((k % (i + 2)) == 0);
    return v;
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs(d8..d2) actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: numbers the pulse, queues its expectation, then shapes it
  task automatic drive_pulse(input int hi, input int lo);
    exp_item_t it;
    pulse_no++;
    it.vec = expect_for(pulse_no);
    it.hi  = hi;
    exp_q.push_back(it);
    pulse_in = 1'b1;
    repeat (hi) @(negedge clk);
    pulse_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  // Monitor: pops one expectation per input rise and samples the outputs
  initial begin
    forever begin
      exp_item_t it;
      @(posedge pulse_in);
      if (exp_q.size() == 0) begin
        check("R1 queue", 7'd1, 7'd0);
      end else begin
        it = exp_q.pop_front();
        repeat (3) @(negedge clk);
        check("R1/R2 rise", outs_now(), it.vec);
        repeat (it.hi - 1) @(negedge clk);
        check("R3 held high", outs_now(), it.vec);
        @(negedge clk);
        check("R3 fall after input low", outs_now(), 7'd0);
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    pulse_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 reset outputs high", outs_now(), 7'h7F);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 outputs drop after release", outs_now(), 7'd0);

    // R1 R4 R5 R6: full periods of every ratio, short pulses
    for (int i = 0; i < 24; i++) drive_pulse(4, 4);
    // R8: long-held input counts once per pulse
    for (int i = 0; i < 10; i++) drive_pulse(9, 5);
    check("R8 count continued", outs_now(), 7'd0);

    // R7: mid-stream reset restarts all counts at 1
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 mid-stream reset high", outs_now(), 7'h7F);
    rst = 1'b0;
    pulse_no = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) drive_pulse(3, 6);
    for (int i = 0; i < 8; i++) drive_pulse(2, 4);

    repeat (10) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1: pending expectations actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule